// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This unit settles the outcome of the eight flag-conditioned relative branches of an 8-bit processor. Each request carries four items:

- the opcode byte;
- a signed 8-bit displacement;
- the negative, zero, carry and overflow flags;
- the 16-bit address of the byte that follows the two-byte branch.

From these the unit works out three results. It decides whether the branch is taken. It forms the next program counter. It counts the cycles the instruction costs, including the extra cost of a taken branch and of landing in a different 256-byte page.

The sequencer raises `valid_i` for one cycle with a decoded request. On that clock edge the unit registers its results. It raises `done_o` for exactly one cycle afterwards, and the results stay put until the next request. Any opcode outside the branch group gets the same treatment as a branch whose condition fails, with two differences: it raises `illegal_o` and reports a cycle count of zero. The unit has no flag outputs, so a branch cannot alter the status flags.

Top module: `branch_resolver`

## Requirements
- R1: An opcode is a branch only when its low five bits are 10000. Any other opcode gives `illegal_o`=1, `taken_o`=0, `cycles_o`=0 and `next_pc_o` equal to the sequential address.
- R2: Opcode bits [7:6] choose the flag under test: 00 tests N, 01 tests V, 10 tests C, 11 tests Z. The other three flags have no effect on the outcome.
- R3: Opcode bit 5 sets the polarity. When it is 1 the branch is taken if the chosen flag is 1. When it is 0 the branch is taken if the chosen flag is 0.
- R4: A taken branch gives `next_pc_o` = sequential address + sign-extended displacement, wrapped modulo 65536.
- R5: A branch that is not taken gives `next_pc_o` equal to the sequential address and `cycles_o`=2.
- R6: A taken branch whose target keeps the high byte of the sequential address gives `cycles_o`=3.
- R7: A taken branch whose target has a different high byte gives `cycles_o`=4. This includes wraps across address 0.
- R8: Results are registered on the edge where `valid_i` is 1, and `done_o` is 1 for the following cycle only. While `valid_i` is 0, every result output holds its value.
- R9: A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe, one cycle |
| opcode_i | input | 8 | Opcode byte |
| disp_i | input | 8 | Signed displacement |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| seq_pc_i | input | 16 | Address after the branch instruction |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| cycles_o | output | 3 | Instruction cycle count |
| illegal_o | output | 1 | Opcode is not a conditional branch |
| done_o | output | 1 | Results updated on the previous edge |

## Verification
The checker compares registered results against the request inputs as they were one cycle earlier. It therefore assumes that `opcode_i`, `disp_i`, the flags and `seq_pc_i` are stable and known on every edge where `valid_i` is high. The bench drives all inputs on the falling edge, so each request is settled well before the capturing rising edge. It also holds `valid_i` high for exactly one cycle per request. Between requests the bench changes the inputs without the strobe, which exercises the hold property against values the unit must ignore.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {
      SEL_N = 2'd0,
      SEL_V = 2'd1,
      SEL_C = 2'd2,
      SEL_Z = 2'd3
   } flag_sel_e;

   typedef struct packed {
      logic      legal;
      flag_sel_e sel;
      logic      want_set;
   } cond_t;

   localparam logic [4:0] BRANCH_LOW = 5'b10000;
endpackage

// File: rtl/br_cond_decode.sv
module br_cond_decode
   import br_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0] opcode,
   input  logic            fl_n,
   input  logic            fl_z,
   input  logic            fl_c,
   input  logic            fl_v,
   output logic            legal,
   output logic            cond_met
);
   localparam int SEL_MSB = OP_W - 1;
   localparam int POL_BIT = OP_W - 3;

   generate
      if (OP_W != 8) begin : g_bad_width
         $error("br_cond_decode: opcode map assumes 8-bit opcodes");
      end
   endgenerate

   cond_t      cond;
   logic [3:0] flag_vec;

   always_comb begin
      cond.legal    = (opcode[POL_BIT-1:0] == BRANCH_LOW);
      cond.sel      = flag_sel_e'(opcode[SEL_MSB -: 2]);
      cond.want_set = opcode[POL_BIT];
      flag_vec[SEL_N] = fl_n;
      flag_vec[SEL_V] = fl_v;
      flag_vec[SEL_C] = fl_c;
      flag_vec[SEL_Z] = fl_z;
   end

   assign legal    = cond.legal;
   assign cond_met = cond.legal && (flag_vec[cond.sel] == cond.want_set);
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8,
   parameter int PAGE_W = 8
) (
   input  logic [ADDR_W-1:0] seq_pc,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] target,
   output logic              page_cross
);
   localparam int EXT_W = ADDR_W - DISP_W;

   generate
      if (PAGE_W >= ADDR_W) begin : g_bad_page
         $error("br_target_calc: page width must be below address width");
      end
      if (EXT_W > 0) begin : g_extend
         assign target = seq_pc + {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_trunc
         assign target = seq_pc + disp[ADDR_W-1:0];
      end
   endgenerate

   assign page_cross = (target[ADDR_W-1:PAGE_W] != seq_pc[ADDR_W-1:PAGE_W]);
endmodule

// File: rtl/br_cycle_count.sv
module br_cycle_count #(
   parameter int CYC_W     = 3,
   parameter int BASE_CYC  = 2,
   parameter int TAKEN_PEN = 1,
   parameter int CROSS_PEN = 1
) (
   input  logic             legal,
   input  logic             taken,
   input  logic             page_cross,
   output logic [CYC_W-1:0] cycles
);
   localparam int MAX_CYC = BASE_CYC + TAKEN_PEN + CROSS_PEN;

   generate
      if (MAX_CYC >= (1 << CYC_W)) begin : g_bad_cyc
         $error("br_cycle_count: CYC_W too narrow for worst case");
      end
   endgenerate

   always_comb begin
      if (!legal) begin
         cycles = '0;
      end else if (!taken) begin
         cycles = CYC_W'(BASE_CYC);
      end else if (page_cross) begin
         cycles = CYC_W'(MAX_CYC);
      end else begin
         cycles = CYC_W'(BASE_CYC + TAKEN_PEN);
      end
   end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
   parameter int ADDR_W    = 16,
   parameter int DISP_W    = 8,
   parameter int OP_W      = 8,
   parameter int PAGE_W    = 8,
   parameter int CYC_W     = 3,
   parameter int BASE_CYC  = 2,
   parameter int TAKEN_PEN = 1,
   parameter int CROSS_PEN = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic              flag_n_i,
   input  logic              flag_z_i,
   input  logic              flag_c_i,
   input  logic              flag_v_i,
   input  logic [ADDR_W-1:0] seq_pc_i,
   output logic              taken_o,
   output logic [ADDR_W-1:0] next_pc_o,
   output logic [CYC_W-1:0]  cycles_o,
   output logic              illegal_o,
   output logic              done_o
);
   generate
      if (DISP_W > ADDR_W) begin : g_bad_disp
         $error("branch_resolver: displacement wider than address");
      end
   endgenerate

   logic              legal_c;
   logic              met_c;
   logic [ADDR_W-1:0] target_c;
   logic              cross_c;
   logic [CYC_W-1:0]  cyc_c;
   logic [ADDR_W-1:0] npc_c;

   br_cond_decode #(.OP_W(OP_W)) u_dec (
      .opcode   (opcode_i),
      .fl_n     (flag_n_i),
      .fl_z     (flag_z_i),
      .fl_c     (flag_c_i),
      .fl_v     (flag_v_i),
      .legal    (legal_c),
      .cond_met (met_c)
   );

   br_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W)) u_tgt (
      .seq_pc     (seq_pc_i),
      .disp       (disp_i),
      .target     (target_c),
      .page_cross (cross_c)
   );

   br_cycle_count #(
      .CYC_W(CYC_W), .BASE_CYC(BASE_CYC),
      .TAKEN_PEN(TAKEN_PEN), .CROSS_PEN(CROSS_PEN)
   ) u_cyc (
      .legal      (legal_c),
      .taken      (met_c),
      .page_cross (cross_c),
      .cycles     (cyc_c)
   );

   assign npc_c = met_c ? target_c : seq_pc_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         taken_o   <= 1'b0;
         next_pc_o <= '0;
         cycles_o  <= '0;
         illegal_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= valid_i;
         if (valid_i) begin
            taken_o   <= met_c;
            next_pc_o <= npc_c;
            cycles_o  <= cyc_c;
            illegal_o <= !legal_c;
         end
      end
   end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
   parameter int ADDR_W = 16,
   parameter int DISP_W = 8,
   parameter int OP_W   = 8,
   parameter int PAGE_W = 8,
   parameter int CYC_W  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_i,
   input logic [OP_W-1:0]   opcode_i,
   input logic [DISP_W-1:0] disp_i,
   input logic [ADDR_W-1:0] seq_pc_i,
   input logic              taken_o,
   input logic [ADDR_W-1:0] next_pc_o,
   input logic [CYC_W-1:0]  cycles_o,
   input logic              illegal_o,
   input logic              done_o
);
   localparam int EXT_W = ADDR_W - DISP_W;

   assert_done_follows_valid_R8: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> done_o);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !done_o);

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(next_pc_o) && $stable(cycles_o) && $stable(taken_o) && $stable(illegal_o)));

   assert_illegal_R1: assert property (@(posedge clk) disable iff (rst)
      (valid_i && opcode_i[4:0] != 5'b10000) |=>
         (illegal_o && !taken_o && cycles_o == '0 && next_pc_o == $past(seq_pc_i)));

   assert_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
      (done_o && !illegal_o && !taken_o) |-> (cycles_o == CYC_W'(2)));

   assert_target_R4: assert property (@(posedge clk) disable iff (rst)
      (valid_i ##1 (taken_o && !illegal_o)) |->
         (next_pc_o == $past(seq_pc_i) + {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

   assert_same_page_R6: assert property (@(posedge clk) disable iff (rst)
      (valid_i ##1 (taken_o && !illegal_o && next_pc_o[ADDR_W-1:PAGE_W] == $past(seq_pc_i[ADDR_W-1:PAGE_W])))
         |-> (cycles_o == CYC_W'(3)));

   assert_cross_page_R7: assert property (@(posedge clk) disable iff (rst)
      (valid_i ##1 (taken_o && !illegal_o && next_pc_o[ADDR_W-1:PAGE_W] != $past(seq_pc_i[ADDR_W-1:PAGE_W])))
         |-> (cycles_o == CYC_W'(4)));
endmodule

bind branch_resolver branch_resolver_chk #(
   .ADDR_W(ADDR_W), .DISP_W(DISP_W), .OP_W(OP_W), .PAGE_W(PAGE_W), .CYC_W(CYC_W)
) u_chk (
   .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i), .disp_i(disp_i),
   .seq_pc_i(seq_pc_i), .taken_o(taken_o), .next_pc_o(next_pc_o),
   .cycles_o(cycles_o), .illegal_o(illegal_o), .done_o(done_o)
);

// File: tb/test_branch_resolver.sv
`timescale 1ns/1ps
module test_branch_resolver;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [7:0]  opcode_i = '0;
   logic [7:0]  disp_i = '0;
   logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_c_i = 1'b0, flag_v_i = 1'b0;
   logic [15:0] seq_pc_i = '0;
   logic        taken_o;
   logic [15:0] next_pc_o;
   logic [2:0]  cycles_o;
   logic        illegal_o;
   logic        done_o;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc_count = 0;

   always #2.5 clk = ~clk;

   branch_resolver i_branch_resolver (
      .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i), .disp_i(disp_i),
      .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .flag_v_i(flag_v_i),
      .seq_pc_i(seq_pc_i), .taken_o(taken_o), .next_pc_o(next_pc_o),
      .cycles_o(cycles_o), .illegal_o(illegal_o), .done_o(done_o)
   );

   typedef struct packed {
      logic [7:0]  op;
      logic [7:0]  disp;
      logic [3:0]  nzcv;
      logic [15:0] seq;
      logic        taken;
      logic [15:0] pc;
      logic [2:0]  cyc;
      logic        ill;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{8'h10, 8'h05, 4'b0000, 16'h1000, 1'b1, 16'h1005, 3'd3, 1'b0},
      '{8'h10, 8'h05, 4'b1000, 16'h1000, 1'b0, 16'h1000, 3'd2, 1'b0},
      '{8'h30, 8'hFB, 4'b1000, 16'h1000, 1'b1, 16'h0FFB, 3'd4, 1'b0},
      '{8'h50, 8'h10, 4'b0000, 16'h20F0, 1'b1, 16'h2100, 3'd4, 1'b0},
      '{8'h70, 8'h10, 4'b0001, 16'h2080, 1'b1, 16'h2090, 3'd3, 1'b0},
      '{8'h90, 8'h7F, 4'b0010, 16'h3000, 1'b0, 16'h3000, 3'd2, 1'b0},
      '{8'hB0, 8'h7F, 4'b0010, 16'h3000, 1'b1, 16'h307F, 3'd3, 1'b0},
      '{8'hD0, 8'h80, 4'b0000, 16'h4080, 1'b1, 16'h4000, 3'd3, 1'b0},
      '{8'hF0, 8'h80, 4'b0100, 16'h4070, 1'b1, 16'h3FF0, 3'd4, 1'b0},
      '{8'hF0, 8'h02, 4'b0000, 16'h5000, 1'b0, 16'h5000, 3'd2, 1'b0},
      '{8'hD0, 8'h10, 4'b0000, 16'hFFF8, 1'b1, 16'h0008, 3'd4, 1'b0},
      '{8'h4C, 8'h05, 4'b0000, 16'h6000, 1'b0, 16'h6000, 3'd0, 1'b1},
      '{8'h00, 8'h05, 4'b1111, 16'h7000, 1'b0, 16'h7000, 3'd0, 1'b1},
      '{8'h18, 8'h05, 4'b0000, 16'h7100, 1'b0, 16'h7100, 3'd0, 1'b1},
      '{8'h30, 8'h00, 4'b1000, 16'h8000, 1'b1, 16'h8000, 3'd3, 1'b0},
      '{8'h10, 8'h02, 4'b0111, 16'h9000, 1'b1, 16'h9002, 3'd3, 1'b0}
   };

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_count++;
      if (cyc_count > 5000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   task automatic apply(input vec_t v);
      @(negedge clk);
      opcode_i = v.op;
      disp_i   = v.disp;
      {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = v.nzcv;
      seq_pc_i = v.seq;
      valid_i  = 1'b1;
      @(negedge clk);
      valid_i  = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", "taken", 32'(taken_o), 0);
      check("R9", "next_pc", 32'(next_pc_o), 0);
      check("R9", "cycles", 32'(cycles_o), 0);
      check("R9", "illegal", 32'(illegal_o), 0);
      check("R9", "done", 32'(done_o), 0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         string tag;
         apply(VECS[i]);
         if (VECS[i].ill) tag = "R1";
         else if (!VECS[i].taken) tag = "R5";
         else if (VECS[i].cyc == 3'd4) tag = "R7";
         else tag = "R6";
         check("R8", "done", 32'(done_o), 1);
         check("R2/R3", "taken", 32'(taken_o), 32'(VECS[i].taken));
         check(VECS[i].taken ? "R4" : tag, "next_pc", 32'(next_pc_o), 32'(VECS[i].pc));
         check(tag, "cycles", 32'(cycles_o), 32'(VECS[i].cyc));
         check("R1", "illegal", 32'(illegal_o), 32'(VECS[i].ill));
      end

      // R8: inputs change without the strobe; results hold, done drops
      @(negedge clk);
      opcode_i = 8'h10; disp_i = 8'h40; seq_pc_i = 16'hABCD;
      {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = 4'b0000;
      @(negedge clk);
      check("R8", "done low", 32'(done_o), 0);
      check("R8", "hold next_pc", 32'(next_pc_o), 32'h9002);
      check("R8", "hold cycles", 32'(cycles_o), 3);
      check("R8", "hold taken", 32'(taken_o), 1);

      // R9: reset after activity clears everything
      apply('{8'h30, 8'hFB, 4'b1000, 16'h1000, 1'b1, 16'h0FFB, 3'd4, 1'b0});
      rst = 1'b1;
      @(negedge clk);
      check("R9", "taken", 32'(taken_o), 0);
      check("R9", "next_pc", 32'(next_pc_o), 0);
      check("R9", "cycles", 32'(cycles_o), 0);
      check("R9", "done", 32'(done_o), 0);
      rst = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule